// File: doc/BRIEF.md
# Calibration Segment Record Scanner

This engine inspects a small non-volatile calibration segment through a synchronous byte-wide read port. On a start pulse it reads the whole segment once to confirm an integrity word held in its first two bytes. It then walks a chain of tag-length-value records that fills the rest of the segment. Each record is handed out on a valid/ready stream as its tag byte, its length byte and the byte offset at which its value begins. Downstream logic can therefore find calibration entries by tag rather than by fixed address.

The integrity word is the 16-bit two's complement of the XOR of every little-endian word that follows it. A record's length byte follows its tag, and the next tag sits right after the value. The walk must land exactly on the end of the segment. A length that runs off the end, a tag that reads as erased flash, or a single stray byte left at the end stops the walk with a distinct error code. The integrity verdict and the error code are held until the next scan starts.

Top module: `tlv_walker`

## Requirements
- R1: After reset, busy, done, rec_valid and mem_rd_en are 0, err_code is 0 and cks_ok is 0.
- R2: Words are little-endian: the byte at the even offset is the low byte. The check passes when the stored word (offset 0 low, offset 1 high) plus the XOR of the 31 words at offsets 2..63 is 0 modulo 2^16. A passing check gives cks_ok = 1 at the end of the scan.
- R3: A failed integrity check gives cks_ok = 0, but the record walk still runs and still emits every record.
- R4: The first tag is at offset 2 and its length byte is at offset 3. Each emitted record carries its tag, its length, and a value offset equal to the tag offset plus 2. The next tag is at the tag offset plus 2 plus the length.
- R5: While rec_valid is 1 and rec_ready is 0, rec_valid, rec_tag, rec_len and rec_off hold their values. Each handshake consumes exactly one record.
- R6: A walk that reaches offset 64 exactly ends with err_code = 0.
- R7: If tag offset + 2 + length > 64, the walk stops with err_code = 1 and that record is not emitted. A sum of exactly 64 is legal.
- R8: A tag byte of 0xFF stops the walk with err_code = 2 and that record is not emitted.
- R9: If the next tag would fall at offset 63, so that no length byte can follow it, the walk stops with err_code = 3.
- R10: done is a single-cycle pulse at the end of a scan, and busy is 0 in that cycle. cks_ok and err_code then stay unchanged until the next start.
- R11: A start pulse while busy is 1 is ignored: the scan in progress neither restarts nor emits extra records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| cks_ok | output | 1 | Integrity check passed (held) |
| err_code | output | 2 | Walk result: 0 ok, 1 overrun, 2 erased tag, 3 stray byte (held) |
| mem_rd_en | output | 1 | Segment read request |
| mem_rd_addr | output | 6 | Segment byte offset to read |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_tag | output | 8 | Record tag byte |
| rec_len | output | 8 | Record length byte |
| rec_off | output | 7 | Offset of the record's first value byte (0..64) |

## Verification
The bench builds the block with its defaults: a 64-byte segment, a 2-byte integrity word and 0xFF as the erased tag. With these values every walk ending is in reach, including a zero-length record whose value offset is exactly 64 and a single record that fills the segment to the last byte. A reference walk and integrity sum run in the bench on the same byte array that backs the read port. Each scenario is also run with a stuttering ready signal, so the hold behaviour and the one-record-per-handshake rule meet real back-pressure.

// File: rtl/tlv_pkg.sv
// Shared types for the segment record scanner.
// Assumes: one-hot-free binary state coding is acceptable.
package tlv_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CK_RD,
        ST_CK_END,
        ST_CK_EVAL,
        ST_W_TAG,
        ST_W_LEN,
        ST_W_CHK,
        ST_W_OUT
    } tlv_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_OVERRUN = 2'd1,
        ERR_ERASED  = 2'd2,
        ERR_STRAY   = 2'd3
    } tlv_err_e;
endpackage

// File: rtl/tlv_xor_acc.sv
// Integrity accumulator: folds a byte stream into an XOR of little-endian
// words, keeps the header word apart, and reports whether header + XOR is zero.
// Assumes: bytes arrive with their segment offset; header occupies the first
// word; clr and vld never coincide.
module tlv_xor_acc #(
    parameter int BYTE_W   = 8,
    parameter int WORD_B   = 2,
    parameter int AW       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              vld,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] data,
    output logic              pass
);
    localparam int WORD_W = BYTE_W * WORD_B;
    localparam int LSB_W  = (WORD_B > 1) ? $clog2(WORD_B) : 1;

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] stored;
    logic [WORD_W-1:0] sum;
    logic [LSB_W-1:0]  lane;
    logic              in_hdr;

    assign lane   = LSB_W'(addr % WORD_B);
    assign in_hdr = (32'(addr) < WORD_B);

    for (genvar g = 0; g < WORD_B; g++) begin : g_lane
        logic [BYTE_W-1:0] acc_b;
        logic [BYTE_W-1:0] st_b;
        // Per byte lane: capture the header byte or fold a body byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc_b <= '0;
                st_b  <= '0;
            end else if (vld && lane == LSB_W'(g)) begin
                if (in_hdr) st_b  <= data;
                else        acc_b <= acc_b ^ data;
            end
        end
        assign acc[g*BYTE_W +: BYTE_W]    = acc_b;
        assign stored[g*BYTE_W +: BYTE_W] = st_b;
    end

    // Modular sum of header and folded body must vanish for a pass.
    always_comb begin
        sum  = acc + stored;
        pass = (sum == '0);
    end
endmodule

// File: rtl/tlv_rec_step.sv
// Record stepper: from a tag offset and a length byte, derives the value
// offset, the next tag offset and whether the record runs past the segment.
// Assumes: ptr is at most SEG_BYTES-2 when the result is used.
module tlv_rec_step #(
    parameter int SEG_BYTES = 64,
    parameter int HDR       = 2,
    parameter int BYTE_W    = 8,
    parameter int PW        = 7
) (
    input  logic [PW-1:0]     ptr,
    input  logic [BYTE_W-1:0] len,
    output logic [PW-1:0]     val_off,
    output logic [PW-1:0]     next_ptr,
    output logic              overrun
);
    localparam int SW = (BYTE_W > PW ? BYTE_W : PW) + 2;

    logic [SW-1:0] span;

    // Wide addition so a large length cannot wrap into a legal offset.
    always_comb begin
        span     = SW'(ptr) + SW'(len) + SW'(HDR);
        val_off  = PW'(SW'(ptr) + SW'(HDR));
        next_ptr = span[PW-1:0];
        overrun  = (span > SW'(SEG_BYTES));
    end
endmodule

// File: rtl/tlv_out_reg.sv
// Output record register: loads one record and holds it until accepted.
// Assumes: load is only raised when no record is pending.
module tlv_out_reg #(
    parameter int BYTE_W = 8,
    parameter int PW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] tag_in,
    input  logic [BYTE_W-1:0] len_in,
    input  logic [PW-1:0]     off_in,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] tag,
    output logic [BYTE_W-1:0] len,
    output logic [PW-1:0]     off
);
    // Hold the record stable until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            len   <= '0;
            off   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            tag   <= tag_in;
            len   <= len_in;
            off   <= off_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tlv_walker.sv
// Segment record scanner top: sweeps the segment for the integrity check,
// then walks tag/length records and streams them out.
// Assumes: read data returns one cycle after mem_rd_en; segment is a power
// of two bytes long.
module tlv_walker #(
    parameter int          SEG_BYTES  = 64,
    parameter int          BYTE_W     = 8,
    parameter int          WORD_B     = 2,
    parameter logic [7:0]  ERASED_TAG = 8'hFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic                          cks_ok,
    output logic [1:0]                    err_code,
    output logic                          mem_rd_en,
    output logic [$clog2(SEG_BYTES)-1:0]  mem_rd_addr,
    input  logic [BYTE_W-1:0]             mem_rd_data,
    output logic                          rec_valid,
    input  logic                          rec_ready,
    output logic [BYTE_W-1:0]             rec_tag,
    output logic [BYTE_W-1:0]             rec_len,
    output logic [$clog2(SEG_BYTES):0]    rec_off
);
    import tlv_pkg::*;

    localparam int AW  = $clog2(SEG_BYTES);
    localparam int PW  = AW + 1;
    localparam int HDR = WORD_B;

    tlv_state_e        state;
    tlv_err_e          err_q;
    logic [PW-1:0]     ptr;
    logic [AW-1:0]     ck_cnt;
    logic              cap_vld;
    logic [AW-1:0]     cap_addr;
    logic [BYTE_W-1:0] tag_q;
    logic              cks_ok_q;
    logic              done_q;
    logic              sum_pass;
    logic [PW-1:0]     val_off;
    logic [PW-1:0]     next_ptr;
    logic              overrun;
    logic              out_load;

    tlv_xor_acc #(.BYTE_W(BYTE_W), .WORD_B(WORD_B), .AW(AW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE && start),
        .vld   (cap_vld),
        .addr  (cap_addr),
        .data  (mem_rd_data),
        .pass  (sum_pass)
    );

    tlv_rec_step #(.SEG_BYTES(SEG_BYTES), .HDR(HDR), .BYTE_W(BYTE_W), .PW(PW)) u_step (
        .ptr      (ptr),
        .len      (mem_rd_data),
        .val_off  (val_off),
        .next_ptr (next_ptr),
        .overrun  (overrun)
    );

    assign out_load = (state == ST_W_CHK) && (tag_q != ERASED_TAG) && !overrun;

    tlv_out_reg #(.BYTE_W(BYTE_W), .PW(PW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (out_load),
        .tag_in (tag_q),
        .len_in (mem_rd_data),
        .off_in (val_off),
        .ready  (rec_ready),
        .valid  (rec_valid),
        .tag    (rec_tag),
        .len    (rec_len),
        .off    (rec_off)
    );

    // Read port: sequential sweep, then tag and length fetches of the walk.
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        unique case (state)
            ST_CK_RD: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = ck_cnt;
            end
            ST_W_TAG: begin
                mem_rd_en   = (ptr < PW'(SEG_BYTES - 1));
                mem_rd_addr = ptr[AW-1:0];
            end
            ST_W_LEN: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = AW'(ptr + PW'(1));
            end
            default: ;
        endcase
    end

    // Main sequencer: integrity sweep, verdict, then record walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            err_q    <= ERR_NONE;
            ptr      <= '0;
            ck_cnt   <= '0;
            cap_vld  <= 1'b0;
            cap_addr <= '0;
            tag_q    <= '0;
            cks_ok_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            cap_vld  <= (state == ST_CK_RD);
            cap_addr <= ck_cnt;
            unique case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_CK_RD;
                    ck_cnt   <= '0;
                    err_q    <= ERR_NONE;
                    cks_ok_q <= 1'b0;
                end
                ST_CK_RD: begin
                    ck_cnt <= ck_cnt + 1'b1;
                    if (ck_cnt == AW'(SEG_BYTES - 1)) state <= ST_CK_END;
                end
                ST_CK_END: state <= ST_CK_EVAL;
                ST_CK_EVAL: begin
                    cks_ok_q <= sum_pass;
                    ptr      <= PW'(HDR);
                    state    <= ST_W_TAG;
                end
                ST_W_TAG: begin
                    if (ptr == PW'(SEG_BYTES)) begin
                        err_q <= ERR_NONE;  state <= ST_IDLE; done_q <= 1'b1;
                    end else if (ptr == PW'(SEG_BYTES - 1)) begin
                        err_q <= ERR_STRAY; state <= ST_IDLE; done_q <= 1'b1;
                    end else begin
                        state <= ST_W_LEN;
                    end
                end
                ST_W_LEN: begin
                    tag_q <= mem_rd_data;
                    state <= ST_W_CHK;
                end
                ST_W_CHK: begin
                    if (tag_q == ERASED_TAG) begin
                        err_q <= ERR_ERASED;  state <= ST_IDLE; done_q <= 1'b1;
                    end else if (overrun) begin
                        err_q <= ERR_OVERRUN; state <= ST_IDLE; done_q <= 1'b1;
                    end else begin
                        ptr   <= next_ptr;
                        state <= ST_W_OUT;
                    end
                end
                ST_W_OUT: if (rec_valid && rec_ready) state <= ST_W_TAG;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign cks_ok   = cks_ok_q;
    assign err_code = err_q;
endmodule

// File: rtl/tlv_walker_chk.sv
// Property checker for the record scanner, bound to every tlv_walker.
// Assumes: synchronous active-low reset on rst_n.
module tlv_walker_chk #(
    parameter int         SEG_BYTES  = 64,
    parameter int         BYTE_W     = 8,
    parameter logic [7:0] ERASED_TAG = 8'hFF
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         done,
    input logic                         rec_valid,
    input logic                         rec_ready,
    input logic [BYTE_W-1:0]            rec_tag,
    input logic [BYTE_W-1:0]            rec_len,
    input logic [$clog2(SEG_BYTES):0]   rec_off
);
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_tag)
                                    && $stable(rec_len) && $stable(rec_off));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_value_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (32'(rec_off) + 32'(rec_len)) <= SEG_BYTES);

    p_no_erased_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_tag != ERASED_TAG);
endmodule

bind tlv_walker tlv_walker_chk #(
    .SEG_BYTES (SEG_BYTES),
    .BYTE_W    (BYTE_W),
    .ERASED_TAG(ERASED_TAG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_tag   (rec_tag),
    .rec_len   (rec_len),
    .rec_off   (rec_off)
);

// File: tb/tlv_walker_test.sv
// Directed bench for the segment record scanner.
module tlv_walker_test;
    localparam int PERIOD = 10;
    localparam int SEG    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, cks_ok, mem_rd_en, rec_valid;
    logic       rec_ready = 1'b0;
    logic [1:0] err_code;
    logic [5:0] mem_rd_addr;
    logic [7:0] mem_rd_data;
    logic [7:0] rec_tag, rec_len;
    logic [6:0] rec_off;

    logic [7:0] mem [SEG];
    int n_chk = 0;
    int n_err = 0;
    int exp_tag [32];
    int exp_len [32];
    int exp_off [32];
    int exp_n, exp_err, exp_ck;

    always #(PERIOD/2) clk = ~clk;

    // Synchronous read port model with one cycle of latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    tlv_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .cks_ok(cks_ok), .err_code(err_code), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_tag(rec_tag),
        .rec_len(rec_len), .rec_off(rec_off)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic seg_clear();
        for (int i = 0; i < SEG; i++) mem[i] = 8'(i * 13 + 5);
    endtask

    task automatic put_rec(int p, int tag, int len);
        mem[p]   = 8'(tag);
        mem[p+1] = 8'(len);
    endtask

    // Stores the integrity word; bad=1 corrupts it by one.
    task automatic seal(bit bad);
        logic [15:0] x = 16'h0;
        logic [15:0] s;
        for (int i = 2; i < SEG; i += 2) x ^= {mem[i+1], mem[i]};
        s = 16'(-x) + (bad ? 16'd1 : 16'd0);
        mem[0] = s[7:0];
        mem[1] = s[15:8];
    endtask

    // Bench reference model of the integrity check and the walk.
    task automatic model();
        logic [15:0] x = 16'h0;
        int p = 2;
        for (int i = 2; i < SEG; i += 2) x ^= {mem[i+1], mem[i]};
        exp_ck  = (16'(x + {mem[1], mem[0]}) == 16'h0) ? 1 : 0;
        exp_n   = 0;
        exp_err = -1;
        while (exp_err < 0) begin
            if (p == SEG)                       exp_err = 0;
            else if (p == SEG - 1)              exp_err = 3;
            else if (mem[p] == 8'hFF)           exp_err = 2;
            else if (p + 2 + int'(mem[p+1]) > SEG) exp_err = 1;
            else begin
                exp_tag[exp_n] = mem[p];
                exp_len[exp_n] = mem[p+1];
                exp_off[exp_n] = p + 2;
                exp_n++;
                p = p + 2 + int'(mem[p+1]);
            end
        end
    endtask

    // Runs one scan. mode 1 stutters ready; restart pulses start mid-scan.
    task automatic run_scan(string req, int mode, bit restart);
        int idx = 0;
        int cyc = 0;
        int dones = 0;
        bit stalled = 1'b0;
        logic [7:0] h_tag, h_len;
        logic [6:0] h_off;
        int s_err, s_ck;
        model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            if (done) break;
            if (cyc > 3000) begin
                chk(req, "watchdog expired", 1, 0);
                break;
            end
            if (restart) start = (cyc == 20 || cyc == 90);
            if (stalled) begin
                chk("R5", "held valid", int'(rec_valid), 1);
                chk("R5", "held tag", int'(rec_tag), int'(h_tag));
                chk("R5", "held len", int'(rec_len), int'(h_len));
                chk("R5", "held off", int'(rec_off), int'(h_off));
            end
            rec_ready = (mode == 0) ? 1'b1 : (cyc % 3 == 2);
            stalled = rec_valid && !rec_ready;
            h_tag = rec_tag; h_len = rec_len; h_off = rec_off;
            if (rec_valid && rec_ready) begin
                if (idx < exp_n) begin
                    chk("R4", "record tag", int'(rec_tag), exp_tag[idx]);
                    chk("R4", "record len", int'(rec_len), exp_len[idx]);
                    chk("R4", "record value offset", int'(rec_off), exp_off[idx]);
                end
                idx++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        rec_ready = 1'b0;
        chk(req, "record count", idx, exp_n);
        chk(req, "err_code", int'(err_code), exp_err);
        chk(exp_ck ? "R2" : "R3", "cks_ok", int'(cks_ok), exp_ck);
        chk("R10", "busy low at done", int'(busy), 0);
        s_err = err_code; s_ck = cks_ok;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R10", "done single pulse", dones, 0);
        chk("R10", "err_code held", int'(err_code), s_err);
        chk("R10", "cks_ok held", int'(cks_ok), s_ck);
        if (restart) chk("R11", "no rescan after ignored start", int'(busy), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "rec_valid", int'(rec_valid), 0);
        chk("R1", "mem_rd_en", int'(mem_rd_en), 0);
        chk("R1", "err_code", int'(err_code), 0);
        chk("R1", "cks_ok", int'(cks_ok), 0);
        rst_n = 1'b1;
    endtask

    task automatic build_good(bit bad);
        seg_clear();
        put_rec(2, 8'h08, 8'h16);
        put_rec(8'h1A, 8'h10, 8'h10);
        put_rec(8'h2C, 8'h01, 8'h12);
        seal(bad);
    endtask

    task automatic t_good();         build_good(0); run_scan("R6", 0, 0); endtask
    task automatic t_backpressure(); build_good(0); run_scan("R5", 1, 0); endtask
    task automatic t_bad_sum();      build_good(1); run_scan("R3", 1, 0); endtask
    task automatic t_restart();      build_good(0); run_scan("R11", 0, 1); endtask

    task automatic t_full_record();
        seg_clear(); put_rec(2, 8'h05, 60); seal(0);
        run_scan("R7", 0, 0);
    endtask

    task automatic t_overrun();
        seg_clear(); put_rec(2, 8'h21, 8'h16); put_rec(8'h1A, 8'h22, 37); seal(0);
        run_scan("R7", 0, 0);
    endtask

    task automatic t_erased();
        seg_clear(); put_rec(2, 8'h08, 8'h16); put_rec(8'h1A, 8'hFF, 8'h04); seal(0);
        run_scan("R8", 1, 0);
    endtask

    task automatic t_stray();
        seg_clear(); put_rec(2, 8'h07, 59); seal(0);
        run_scan("R9", 0, 0);
    endtask

    task automatic t_zero_len();
        seg_clear(); put_rec(2, 8'h0A, 58); put_rec(62, 8'h0B, 0); seal(1);
        run_scan("R4", 0, 0);
    endtask

    initial begin
        t_reset();
        t_good();
        t_backpressure();
        t_bad_sum();
        t_full_record();
        t_overrun();
        t_erased();
        t_stray();
        t_zero_len();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R10 global watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule